// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address for every beat of a memory burst. A burst opens with a one-cycle start request that carries the first column, a burst length code and a wrap-order select. From the next cycle the block presents one column at a time. The downstream command logic takes each column with an advance strobe. The length and wrap order are captured only when a burst opens, so they must be set up before that request. Any change to them while a burst runs has no effect.

Two wrap orders are available. Sequential order counts the low address bits upward and wraps them inside an aligned block of the burst length. Interleaved order XORs the beat number into the low bits of the start column. A full-page burst, which only sequential order allows, walks the whole page and wraps at its end. It stops only when the terminate input is raised. If full page is requested together with interleaved order, an error flag is raised and an 8-beat interleaved burst runs in its place.

The column output is a valid/ready stream: `col_valid` is the valid and `advance` is the ready. A beat is taken on a cycle where both are high. While `advance` is low, the column and `col_valid` are held. The start, terminate and mode pins are plain controls.

Top module: `bsq_burst_seq`

## Requirements
- R1: After reset, col_valid, last_beat and mode_err are all 0.
- R2: A start request while col_valid is 0 opens a burst: on the next cycle col_valid is 1 and col_out equals the start_col sampled with it. A start request while col_valid is 1 is ignored, and the running burst continues unchanged.
- R3: A beat is taken on a cycle with col_valid and advance both 1. While col_valid is 1 and advance and terminate are both 0, col_out and col_valid keep their values.
- R4: The length code bl_code[2:0] is read as follows. Values 0, 1, 2 and 3 give bursts of 1, 2, 4 and 8 beats. Any value with bit 2 set selects full page.
- R5: In sequential order (wrap_ilv = 0) with finite length BL, beat n carries start_col with its low log2(BL) bits replaced by (those bits + n) mod BL. The upper bits do not change.
- R6: In interleaved order (wrap_ilv = 1), beat n carries start_col with its low log2(BL) bits XORed with n.
- R7: last_beat is 1 exactly on the final beat of a finite burst. When that beat is taken, col_valid is 0 on the next cycle.
- R8: A sequential full-page burst gives beat n the column (start_col + n) mod 2^COL_W. It never raises last_beat and keeps running past the page end until terminated.
- R9: terminate while col_valid is 1 ends the burst, so col_valid is 0 on the next cycle. terminate while idle has no effect.
- R10: Full page requested with interleaved order sets mode_err on the cycle after the start, and an 8-beat interleaved burst runs. mode_err holds until the next accepted start, which clears it if that start is legal.
- R11: bl_code, wrap_ilv and start_col are used only on the cycle a burst opens. Changes during the burst do not alter its column sequence or its length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Open a burst (taken only when idle) |
| start_col | input | COL_W | First column of the burst |
| bl_code | input | 3 | Burst length code (R4) |
| wrap_ilv | input | 1 | 0 = sequential order, 1 = interleaved order |
| advance | input | 1 | Ready: take the presented column |
| terminate | input | 1 | End the running burst |
| col_out | output | COL_W | Column of the current beat |
| col_valid | output | 1 | Valid: a burst is open and col_out is meaningful |
| last_beat | output | 1 | Current beat is the final one of a finite burst |
| mode_err | output | 1 | Last accepted start asked for an illegal mode pair |

## Verification
The hardest condition to reach from the ports is the full-page wrap across the end of the page. It needs a few hundred accepted beats with no terminate and no stray last_beat. The stimulus opens a full-page burst near the top of the page and keeps advance high past column 255 and back around. Only then does it terminate. A second hard point is a start request and mode changes that arrive while a burst is open. For this, the stimulus drives a different start column, length and order in the middle of a burst and checks that the original sequence runs to its end.

// File: rtl/bsq_pkg.sv
package bsq_pkg;
  // Width of the length code and fixed limit of finite bursts.
  localparam int LEN_CODE_W   = 3;
  localparam int MAX_LEN_LOG2 = 3;

  typedef enum logic {
    ORDER_SEQ = 1'b0,
    ORDER_ILV = 1'b1
  } order_e;

  // Burst settings captured when a burst opens.
  typedef struct packed {
    logic   full_page;
    order_e order;
    logic   bad_pair;
  } burst_cfg_t;
endpackage

// File: rtl/bsq_mode_dec.sv
module bsq_mode_dec
  import bsq_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [LEN_CODE_W-1:0] len_code,
  input  logic                  ilv_sel,
  output burst_cfg_t            cfg,
  output logic [COL_W-1:0]      low_mask
);
  localparam int LOG_W = $clog2(MAX_LEN_LOG2 + 1);

  logic             want_full;
  logic [LOG_W-1:0] len_log2;

  assign want_full     = len_code[LEN_CODE_W-1];
  assign cfg.bad_pair  = want_full & ilv_sel;
  assign cfg.full_page = want_full & ~ilv_sel;
  assign cfg.order     = ilv_sel ? ORDER_ILV : ORDER_SEQ;

  // An illegal pair falls back to the longest finite burst.
  always_comb begin
    if (cfg.bad_pair) len_log2 = LOG_W'(MAX_LEN_LOG2);
    else              len_log2 = LOG_W'(len_code[LEN_CODE_W-2:0]);
  end

  // One mask bit per column bit: set when that bit lies inside the wrap block.
  for (genvar i = 0; i < COL_W; i++) begin : g_mask
    assign low_mask[i] = cfg.full_page | (int'(len_log2) > i);
  end
endmodule

// File: rtl/bsq_beat_ctr.sv
module bsq_beat_ctr #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic             take,
  input  logic             stop,
  input  logic             full_page,
  input  logic [COL_W-1:0] low_mask,
  output logic             active,
  output logic [COL_W-1:0] beat,
  output logic             final_beat
);
  logic             active_q;
  logic [COL_W-1:0] beat_q;

  // In a finite burst the beat index never exceeds BL-1, which equals the mask.
  assign final_beat = active_q & ~full_page & (beat_q == low_mask);
  assign active     = active_q;
  assign beat       = beat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      beat_q   <= '0;
    end else if (launch) begin
      active_q <= 1'b1;
      beat_q   <= '0;
    end else if (active_q) begin
      if (stop) begin
        active_q <= 1'b0;
      end else if (take) begin
        if (final_beat) active_q <= 1'b0;
        beat_q <= beat_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bsq_addr_gen.sv
module bsq_addr_gen
  import bsq_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] beat,
  input  logic [COL_W-1:0] low_mask,
  input  order_e           order,
  output logic [COL_W-1:0] col
);
  logic [COL_W-1:0] sum;
  logic [COL_W-1:0] seq_col;
  logic [COL_W-1:0] ilv_col;

  // Low bits of a sum depend only on low bits of the operands, so masking
  // after a full-width add gives a modulo-BL count without a separate counter.
  assign sum     = base + beat;
  assign seq_col = (base & ~low_mask) | (sum & low_mask);
  assign ilv_col = base ^ (beat & low_mask);

  always_comb begin
    unique case (order)
      ORDER_ILV: col = ilv_col;
      default:   col = seq_col;
    endcase
  end
endmodule

// File: rtl/bsq_burst_seq.sv
module bsq_burst_seq
  import bsq_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [COL_W-1:0]      start_col,
  input  logic [LEN_CODE_W-1:0] bl_code,
  input  logic                  wrap_ilv,
  input  logic                  advance,
  input  logic                  terminate,
  output logic [COL_W-1:0]      col_out,
  output logic                  col_valid,
  output logic                  last_beat,
  output logic                  mode_err
);
  burst_cfg_t       cfg_d, cfg_q;
  logic [COL_W-1:0] mask_d, mask_q;
  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] beat;
  logic             active;
  logic             launch;

  assign launch = start & ~active;

  bsq_mode_dec #(.COL_W(COL_W)) u_dec (
    .len_code (bl_code),
    .ilv_sel  (wrap_ilv),
    .cfg      (cfg_d),
    .low_mask (mask_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      mask_q <= '0;
      base_q <= '0;
    end else if (launch) begin
      cfg_q  <= cfg_d;
      mask_q <= mask_d;
      base_q <= start_col;
    end
  end

  bsq_beat_ctr #(.COL_W(COL_W)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .launch     (launch),
    .take       (advance),
    .stop       (terminate),
    .full_page  (cfg_q.full_page),
    .low_mask   (mask_q),
    .active     (active),
    .beat       (beat),
    .final_beat (last_beat)
  );

  bsq_addr_gen #(.COL_W(COL_W)) u_gen (
    .base     (base_q),
    .beat     (beat),
    .low_mask (mask_q),
    .order    (cfg_q.order),
    .col      (col_out)
  );

  assign col_valid = active;
  assign mode_err  = cfg_q.bad_pair;
endmodule

// File: rtl/bsq_burst_seq_chk.sv
module bsq_burst_seq_chk #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [COL_W-1:0] start_col,
  input logic [2:0]       bl_code,
  input logic             wrap_ilv,
  input logic             advance,
  input logic             terminate,
  input logic [COL_W-1:0] col_out,
  input logic             col_valid,
  input logic             last_beat,
  input logic             mode_err
);
  a_r2_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (!col_valid && start) |=> (col_valid && col_out == $past(start_col)));

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && !advance && !terminate) |=> (col_valid && $stable(col_out)));

  a_r7_last_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |-> col_valid);

  a_r7_drop_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (last_beat && advance) |=> !col_valid);

  a_r9_terminate: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && terminate) |=> !col_valid);

  a_r10_bad_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (!col_valid && start && wrap_ilv && bl_code[2]) |=> mode_err);

  a_r11_err_stable: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid |=> (!col_valid || $stable(mode_err)));
endmodule

bind bsq_burst_seq bsq_burst_seq_chk #(.COL_W(COL_W)) u_chk (.*);

// File: tb/bsq_burst_seq_tb.sv
module bsq_burst_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int COL_W      = 8;
  localparam int WATCHDOG   = 20000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [COL_W-1:0] start_col = '0;
  logic [2:0]       bl_code = '0;
  logic             wrap_ilv = 1'b0;
  logic             advance = 1'b0;
  logic             terminate = 1'b0;
  logic [COL_W-1:0] col_out;
  logic             col_valid;
  logic             last_beat;
  logic             mode_err;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bsq_burst_seq #(.COL_W(COL_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
    .bl_code(bl_code), .wrap_ilv(wrap_ilv), .advance(advance),
    .terminate(terminate), .col_out(col_out), .col_valid(col_valid),
    .last_beat(last_beat), .mode_err(mode_err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int burst_len(input logic [2:0] code, input bit ilv);
    if (code[2]) return ilv ? 8 : (1 << COL_W);
    return 1 << code[1:0];
  endfunction

  // Expected column of beat n, written from R5, R6, R8 and R10.
  function automatic logic [COL_W-1:0] exp_col(input logic [COL_W-1:0] s,
      input logic [2:0] code, input bit ilv, input int n);
    logic [COL_W-1:0] m;
    if (code[2] && !ilv) return s + COL_W'(n);
    m = COL_W'(burst_len(code, ilv) - 1);
    if (ilv) return s ^ COL_W'(n);
    return (s & ~m) | ((s + COL_W'(n)) & m);
  endfunction

  // Opens a burst, runs 'run' beats, then either expects a natural end or
  // terminates. Optional stalls and mid-burst disturbance.
  task automatic run_burst(input logic [COL_W-1:0] s, input logic [2:0] code,
      input bit ilv, input int run, input bit stall, input bit disturb,
      input string req);
    int  len  = burst_len(code, ilv);
    bit  full = code[2] && !ilv;
    bit  natural_end = !full && (run == len);
    @(negedge clk);
    start = 1'b1; start_col = s; bl_code = code; wrap_ilv = ilv;
    @(negedge clk);
    start = 1'b0;
    chk(col_valid == 1'b1, "R2", "valid after start", int'(col_valid), 1);
    chk(mode_err == (code[2] && ilv), "R10", "mode_err", int'(mode_err),
        int'(code[2] && ilv));
    for (int n = 0; n < run; n++) begin
      chk(col_out == exp_col(s, code, ilv, n), req, $sformatf("col beat %0d", n),
          int'(col_out), int'(exp_col(s, code, ilv, n)));
      chk(last_beat == (!full && n == len - 1), "R7",
          $sformatf("last_beat beat %0d", n), int'(last_beat),
          int'(!full && n == len - 1));
      if (stall && (n % 2 == 0)) begin
        @(negedge clk);
        chk(col_valid && col_out == exp_col(s, code, ilv, n), "R3",
            "held under stall", int'(col_out), int'(exp_col(s, code, ilv, n)));
      end
      if (disturb && n == 1) begin
        start = 1'b1; start_col = ~s; bl_code = ~code; wrap_ilv = ~ilv;
      end
      advance = 1'b1;
      @(negedge clk);
      advance = 1'b0;
      start = 1'b0;
    end
    if (natural_end) begin
      chk(col_valid == 1'b0, "R7", "valid drops after last", int'(col_valid), 0);
    end else begin
      chk(col_valid == 1'b1, "R8", "still open before terminate",
          int'(col_valid), 1);
      terminate = 1'b1;
      @(negedge clk);
      terminate = 1'b0;
      chk(col_valid == 1'b0, "R9", "valid after terminate", int'(col_valid), 0);
    end
  endtask

  task automatic t_reset();
    chk(!col_valid && !last_beat && !mode_err, "R1", "reset outputs",
        int'({col_valid, last_beat, mode_err}), 0);
  endtask

  task automatic t_sequential();
    run_burst(8'h2E, 3'd2, 1'b0, 4, 1'b0, 1'b0, "R5");
    run_burst(8'h5D, 3'd3, 1'b0, 8, 1'b1, 1'b0, "R5");
    run_burst(8'hFF, 3'd0, 1'b0, 1, 1'b0, 1'b0, "R4");
    run_burst(8'h81, 3'd1, 1'b0, 2, 1'b0, 1'b0, "R4");
  endtask

  task automatic t_interleaved();
    run_burst(8'h5D, 3'd3, 1'b1, 8, 1'b0, 1'b0, "R6");
    run_burst(8'h13, 3'd1, 1'b1, 2, 1'b1, 1'b0, "R6");
    run_burst(8'hA6, 3'd2, 1'b1, 4, 1'b0, 1'b0, "R6");
  endtask

  task automatic t_full_page();
    run_burst(8'hF0, 3'd7, 1'b0, 300, 1'b0, 1'b0, "R8");
  endtask

  task automatic t_bad_pair();
    run_burst(8'h34, 3'd4, 1'b1, 8, 1'b0, 1'b0, "R10");
    chk(mode_err == 1'b1, "R10", "err held after burst", int'(mode_err), 1);
    run_burst(8'h10, 3'd1, 1'b0, 2, 1'b0, 1'b0, "R10");
    chk(mode_err == 1'b0, "R10", "err cleared by legal start", int'(mode_err), 0);
  endtask

  task automatic t_busy_start();
    // R2 and R11: start and mode changes mid-burst leave the sequence intact.
    run_burst(8'h6A, 3'd3, 1'b0, 8, 1'b0, 1'b1, "R11");
    run_burst(8'hC5, 3'd3, 1'b1, 8, 1'b1, 1'b1, "R2");
  endtask

  task automatic t_terminate();
    run_burst(8'h40, 3'd3, 1'b0, 3, 1'b0, 1'b0, "R9");
    @(negedge clk);
    terminate = 1'b1;
    @(negedge clk);
    terminate = 1'b0;
    chk(col_valid == 1'b0, "R9", "terminate while idle", int'(col_valid), 0);
    run_burst(8'h07, 3'd2, 1'b0, 4, 1'b0, 1'b0, "R9");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sequential();
    t_interleaved();
    t_full_page();
    t_bad_pair();
    t_busy_start();
    t_terminate();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog run did not finish actual=%0d expected=%0d",
             WATCHDOG, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule